// File: doc/BRIEF.md
# Dual-Style Asynchronous CPU Bus Bridge

This block connects an 8-bit asynchronous microprocessor bus to a small internal register file that runs on the core clock. The bus has an 8-bit address input, an 8-bit bidirectional data bus, an active-low chip select, an address latch enable and two strobe pins. A static style input sets how the two strobe pins are read. With style low, they are separate active-low write and read strobes. With style high, they are a read/write direction level and an active-high enable.

The qualified strobes are decoded straight from the pins and then pass through a two-flop synchronizer. Edge detection on the synchronized levels turns each write strobe into one register write in the core domain, taken when the strobe is released. Read data is driven onto the bus directly from the decoded read condition, so the processor sees it within the strobe. The register file holds four scratch registers, a status register and an interrupt mask. Status bits are set by core-side event pulses and are cleared by reading them. The interrupt output is high while any unmasked status bit is set.

Top module: `cpu_bus_bridge`

## Requirements
- R1: After reset, every scratch register, the status register and the mask read 0x00, and irq is low.
- R2: With bus_style=0, strb_a is an active-low write strobe and strb_b is an active-low read strobe. With cs_n low, a read needs strb_b low and strb_a high, and a write needs strb_a low and strb_b high. Both strobes low, or cs_n high, starts no access.
- R3: With bus_style=1, strb_a is a direction level (1 = read, 0 = write) and strb_b is an active-high enable. An access is qualified while strb_b is high and cs_n is low.
- R4: Each write strobe causes exactly one register update. The update takes effect within three core cycles after the strobe is released. It stores the data present at the end of the strobe, and the data must stay valid for two core cycles after release.
- R5: data_io is driven only while a qualified read is active, and carries the addressed register. At all other times it is high-impedance.
- R6: The address is captured by a transparent latch that is open while ale is high and holds its value after ale falls. With ale tied high, addr_in is used directly.
- R7: Addresses 0x00 to 0x03 are read/write scratch registers. Reading any unmapped address returns 0x00, and writing one changes no register.
- R8: A high cycle on stat_evt[i] sets status bit i. The status register at 0x10 is cleared at the end of a read, but only for the bits that were set when the read began. An event arriving during the read stays pending.
- R9: The mask at 0x11 is read/write. irq is high exactly when (status & mask) is nonzero.
- R10: A write to the status address changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_style | input | 1 | Strobe interpretation: 0 separate strobes, 1 direction plus enable |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch enable (latch open while high) |
| strb_a | input | 1 | Write strobe (style 0) or read/write direction (style 1) |
| strb_b | input | 1 | Read strobe (style 0) or enable (style 1) |
| addr_in | input | 8 | Bus address |
| data_io | inout | 8 | Bidirectional bus data |
| stat_evt | input | 8 | Core-domain status event pulses |
| irq | output | 1 | Interrupt, high while a masked status bit is set |

## Verification
Assertions run on every cycle. They check that a write strobe never produces two back-to-back update pulses and that an update only follows a released strobe. They also check that events always set their status bits, that a completed status read clears exactly the bits it snapshotted, and that the mask and status hold unless the proper access occurs. Other properties can only be shown by the bench's bus transactions: how each style decodes, that the last data value of a strobe wins, the latching of a multiplexed address, the tristate release of data_io, and read-back across sweeps of addresses, data patterns and mask/event combinations.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 8;

  typedef enum logic {
    STYLE_SPLIT  = 1'b0,
    STYLE_DIREN  = 1'b1
  } bus_style_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_req_t;

  localparam logic [BUS_AW-1:0] STAT_ADDR = 8'h10;
  localparam logic [BUS_AW-1:0] MASK_ADDR = 8'h11;
endpackage

// File: rtl/cbb_strobe_decode.sv
module cbb_strobe_decode
  import cbb_pkg::*;
(
  input  logic     style_i,
  input  logic     cs_n_i,
  input  logic     pin_a_i,
  input  logic     pin_b_i,
  output bus_req_t req_o
);
  bus_style_e style;

  always_comb begin
    style = bus_style_e'(style_i);
    req_o = '0;
    if (!cs_n_i) begin
      case (style)
        STYLE_SPLIT: begin
          req_o.rd = !pin_b_i && pin_a_i;
          req_o.wr = !pin_a_i && pin_b_i;
        end
        STYLE_DIREN: begin
          req_o.rd = pin_b_i && pin_a_i;
          req_o.wr = pin_b_i && !pin_a_i;
        end
        default: req_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cbb_sync_edge.sv
module cbb_sync_edge #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;
  logic [W-1:0]             hist_q;

  always_comb begin
    stg_d = stg_q;
    stg_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      hist_q <= '0;
    end else begin
      stg_q  <= stg_d;
      hist_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~hist_q;
  assign fall_o = ~stg_q[STAGES-1] & hist_q;

  generate
    for (genvar b = 0; b < W; b++) begin : g_chk
      // R4: an edge pulse lasts a single cycle
      a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o[b] |=> !fall_o[b]);
    end
  endgenerate
endmodule

// File: rtl/cbb_regfile.sv
module cbb_regfile
  import cbb_pkg::*;
#(
  parameter int unsigned AW   = BUS_AW,
  parameter int unsigned DW   = BUS_DW,
  parameter int unsigned NSCR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_go_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_start_i,
  input  logic          rd_done_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  localparam int unsigned SEL_W = (NSCR > 1) ? $clog2(NSCR) : 1;

  logic [NSCR-1:0][DW-1:0] scr_q;
  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] mask_q, mask_d;
  logic [DW-1:0] snap_q, snap_d;
  logic          hit_stat, hit_mask, hit_scr;

  assign hit_stat = (addr_i == STAT_ADDR);
  assign hit_mask = (addr_i == MASK_ADDR);
  assign hit_scr  = (addr_i < AW'(NSCR));

  generate
    for (genvar i = 0; i < NSCR; i++) begin : g_scr
      logic          we;
      logic [DW-1:0] nxt;
      assign we  = wr_go_i && (addr_i == AW'(i));
      assign nxt = we ? wr_data_i : scr_q[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scr_q[i] <= '0;
        else        scr_q[i] <= nxt;
      end
    end
  endgenerate

  always_comb begin
    snap_d = snap_q;
    if (rd_start_i) snap_d = hit_stat ? stat_q : '0;
    stat_d = stat_q;
    if (rd_done_i) stat_d = stat_d & ~snap_q;
    stat_d = stat_d | evt_i;
    mask_d = (wr_go_i && hit_mask) ? wr_data_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      snap_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (hit_scr)       rd_data_o = scr_q[addr_i[SEL_W-1:0]];
    else if (hit_stat) rd_data_o = stat_q;
    else if (hit_mask) rd_data_o = mask_q;
  end

  assign irq_o = |(stat_q & mask_q);

  // R8: an event always leaves its bit set
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  // R8: a finished read clears the snapshotted bits when no event competes
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_i && evt_i == '0) |=> ((stat_q & $past(snap_q)) == '0));
  // R10: status never changes without an event or a read completion
  a_r10_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done_i && evt_i == '0) |=> $stable(stat_q));
  // R9: mask changes only through a mask write
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go_i && hit_mask) |=> $stable(mask_q));
endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
  import cbb_pkg::*;
#(
  parameter int unsigned AW          = BUS_AW,
  parameter int unsigned DW          = BUS_DW,
  parameter int unsigned NSCR        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_style,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic [AW-1:0] addr_in,
  inout  wire  [DW-1:0] data_io,
  input  logic [DW-1:0] stat_evt,
  output logic          irq
);
  localparam int unsigned CH_RD = 1;
  localparam int unsigned CH_WR = 0;

  logic [1:0]    rst_q;
  logic          rst_core_n;
  bus_req_t      req;
  logic [1:0]    lvl, rise, fall;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rd_data;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  cbb_strobe_decode u_dec (
    .style_i (bus_style),
    .cs_n_i  (cs_n),
    .pin_a_i (strb_a),
    .pin_b_i (strb_b),
    .req_o   (req)
  );

  cbb_sync_edge #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i ({req.rd, req.wr}),
    .lvl_o   (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  // address latch, open while ale is high
  always_latch begin
    if (ale) addr_q <= addr_in;
  end

  // write data follows the bus while the synchronized strobe is high
  assign wdata_d = lvl[CH_WR] ? data_io : wdata_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) wdata_q <= '0;
    else             wdata_q <= wdata_d;
  end

  cbb_regfile #(.AW(AW), .DW(DW), .NSCR(NSCR)) u_rf (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .addr_i     (addr_q),
    .wr_go_i    (fall[CH_WR]),
    .wr_data_i  (wdata_q),
    .rd_start_i (rise[CH_RD]),
    .rd_done_i  (fall[CH_RD]),
    .evt_i      (stat_evt),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  assign data_io = req.rd ? rd_data : {DW{1'bz}};

  // R4: an update pulse is never repeated on the next cycle
  a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    fall[CH_WR] |=> !fall[CH_WR]);
  // R4: an update happens only after the synchronized strobe was high
  a_r4_after_release: assert property (@(posedge clk) disable iff (!rst_core_n)
    fall[CH_WR] |-> (!lvl[CH_WR] && $past(lvl[CH_WR])));
endmodule

// File: tb/sim_cpu_bus_bridge.sv
module sim_cpu_bus_bridge;
  logic       clk;
  logic       rst_n;
  logic       bus_style, cs_n, ale, strb_a, strb_b;
  logic [7:0] addr_in, stat_evt, tb_d;
  logic       tb_oe;
  wire  [7:0] bus;
  logic       irq;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       done = 1'b0;

  assign bus = tb_oe ? tb_d : 8'hzz;

  cpu_bus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n), .ale(ale),
    .strb_a(strb_a), .strb_b(strb_b), .addr_in(addr_in), .data_io(bus),
    .stat_evt(stat_evt), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_idle();
    strb_a = 1'b1;
    strb_b = bus_style ? 1'b0 : 1'b1;
  endtask

  task automatic set_style(input logic s);
    @(negedge clk);
    cs_n = 1'b1;
    bus_style = s;
    set_idle();
  endtask

  // one bus access; rd=1 read, else write (d0 early, d1 at strobe end)
  task automatic acc(input logic rd, input logic [7:0] a, input logic [7:0] d0,
                     input logic [7:0] d1, input logic mux, output logic [7:0] q);
    @(negedge clk);
    addr_in = a;
    ale = 1'b1;
    if (mux) begin
      @(negedge clk);
      ale = 1'b0;
      addr_in = ~a;
    end
    if (!rd) begin tb_oe = 1'b1; tb_d = d0; end
    cs_n = 1'b0;
    if (bus_style) begin strb_a = rd; strb_b = 1'b1; end
    else begin strb_a = rd; strb_b = !rd; end
    repeat (2) @(negedge clk);
    if (!rd) tb_d = d1;
    repeat (2) @(negedge clk);
    q = bus;
    set_idle();
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    tb_oe = 1'b0;
    repeat (3) @(negedge clk);
    ale = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b0, a, d, d, 1'b0, q);
  endtask

  task automatic rdc(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] q;
    acc(1'b1, a, 8'h00, 8'h00, 1'b0, q);
    chk(req, q, exp);
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    stat_evt = e;
    @(negedge clk);
    stat_evt = '0;
  endtask

  initial begin
    logic [7:0] q;
    rst_n = 1'b0; bus_style = 1'b0; cs_n = 1'b1; ale = 1'b1;
    strb_a = 1'b1; strb_b = 1'b1; addr_in = '0; stat_evt = '0;
    tb_oe = 1'b0; tb_d = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 4; a++) rdc("R1 scratch", 8'(a), 8'h00);
    rdc("R1 status", 8'h10, 8'h00);
    rdc("R1 mask", 8'h11, 8'h00);

    // R2/R3/R7: sweep both styles, every scratch register, data patterns
    for (int s = 0; s < 2; s++) begin
      set_style(s[0]);
      for (int p = 0; p < 8; p++) begin
        for (int a = 0; a < 4; a++) wr(8'(a), 8'((a * 37 + p * 71 + s * 13) ^ (1 << p)));
        for (int a = 0; a < 4; a++)
          rdc(s ? "R3 readback" : "R2 readback", 8'(a),
              8'((a * 37 + p * 71 + s * 13) ^ (1 << p)));
      end
    end
    // cross-style: write in style 0, read in style 1
    set_style(1'b0); wr(8'h02, 8'hC3);
    set_style(1'b1); rdc("R3 cross", 8'h02, 8'hC3);

    // R4: last data value of the strobe wins
    for (int s = 0; s < 2; s++) begin
      set_style(s[0]);
      acc(1'b0, 8'h01, 8'h11, 8'hE7 ^ 8'(s), 1'b0, q);
      rdc("R4 late data", 8'h01, 8'hE7 ^ 8'(s));
    end

    // R6: multiplexed address latching, and transparent ale
    set_style(1'b0);
    wr(8'h03, 8'h00);
    acc(1'b0, 8'h01, 8'h77, 8'h77, 1'b1, q);
    rdc("R6 latched target", 8'h01, 8'h77);
    rdc("R6 other untouched", 8'h03, 8'h00);
    acc(1'b1, 8'h01, 8'h00, 8'h00, 1'b1, q);
    chk("R6 latched read", q, 8'h77);

    // R7: unmapped write ignored, unmapped read zero
    wr(8'h00, 8'hFF);
    wr(8'h40, 8'h5A);
    rdc("R7 unmapped read", 8'h40, 8'h00);
    rdc("R7 scratch kept", 8'h00, 8'hFF);
    rdc("R7 scratch kept", 8'h01, 8'h77);

    // R2: both strobes low, or no chip select, starts nothing
    @(negedge clk);
    addr_in = 8'h00; tb_oe = 1'b1; tb_d = 8'h00; cs_n = 1'b0;
    strb_a = 1'b0; strb_b = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 no drive both low", bus, 8'h00);
    set_idle(); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    strb_b = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 no drive cs high", bus, 8'h00);
    set_idle();
    repeat (2) @(negedge clk);
    tb_oe = 1'b0;
    repeat (3) @(negedge clk);
    rdc("R2 no write", 8'h00, 8'hFF);
    set_style(1'b1);
    @(negedge clk);
    tb_oe = 1'b1; tb_d = 8'h00; strb_a = 1'b1; strb_b = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 no drive cs high", bus, 8'h00);
    set_idle();
    repeat (2) @(negedge clk);
    tb_oe = 1'b0;

    // R8/R9: mask by event bit sweep
    for (int m = 0; m < 4; m++) begin
      logic [7:0] mk;
      mk = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : (m == 2) ? 8'hA5 : 8'h3C;
      wr(8'h11, mk);
      rdc("R9 mask readback", 8'h11, mk);
      for (int b = 0; b < 8; b++) begin
        pulse_evt(8'(1 << b));
        chk("R9 irq", {7'd0, irq}, {7'd0, mk[b]});
        rdc("R8 status", 8'h10, 8'(1 << b));
        chk("R9 irq after clear", {7'd0, irq}, 8'h00);
        rdc("R8 cleared", 8'h10, 8'h00);
      end
    end

    // R8: event during a read survives the clear
    pulse_evt(8'h01);
    @(negedge clk);
    addr_in = 8'h10; cs_n = 1'b0; strb_a = 1'b1; strb_b = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 read value", bus, 8'h01);
    stat_evt = 8'h02;
    @(negedge clk);
    stat_evt = 8'h00;
    set_idle(); cs_n = 1'b1;
    repeat (5) @(negedge clk);
    rdc("R8 late event kept", 8'h10, 8'h02);
    rdc("R8 late event cleared", 8'h10, 8'h00);

    // R10: writes to status ignored
    pulse_evt(8'h10);
    wr(8'h10, 8'hFF);
    rdc("R10 status write ignored", 8'h10, 8'h10);
    wr(8'h10, 8'hFF);
    rdc("R10 status stays clear", 8'h10, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule